// File: doc/BRIEF.md
# Reset Qualifier and Emulation-Mode Entry

This block turns the raw reset pin of a small microcontroller into a clean internal reset and decides, at the moment that reset is released, whether the chip comes up in its on-circuit emulation mode. The reset pin only counts once it has stayed high for two full machine cycles of oscillator clocks. Short glitches are ignored. The reset pin, the address-latch strobe pin and the program-store strobe pin are all synchronized before use, so every decision is made on metastability-free copies.

The emulation mode is requested by holding the address-latch strobe low while the chip is in reset with the program-store strobe high. The mode is entered only if the address-latch strobe is still low when the reset releases. Once entered, the mode survives everything except the next qualified reset, and that reset re-decides it at its own release. While the mode is active, the block floats the multiplexed address/data port and selects only weak pull-ups on the other ports and on both strobe pins. A lock input selects whether the external-access strap is sampled continuously or captured during reset and then frozen. A separate power-on reset input, provided by the analog power-on detector, initialises every register.

Top module: `rstemu_top`

## Requirements
- R1: `int_rst` rises only after `rst_pin` has been sampled high on HOLD = CLKS_PER_MC*RST_MCYCLES (default 24) consecutive rising clock edges. It is high after edge k+SYNC_STAGES+HOLD-1 (k+25 by default), where k is the first high sample. A run of 23 high samples never asserts it.
- R2: `int_rst` falls SYNC_STAGES edges after the first low sample of `rst_pin`.
- R3: `emu_mode` becomes 1 at the release of `int_rst` (the same edge at which `int_rst` falls) if two conditions hold. First, during reset `ale_pin` was sampled low while `psen_pin` was high. Second, `ale_pin` is still low on the first low sample of `rst_pin`.
- R4: A qualified reset released with `ale_pin` high leaves `emu_mode` at 0, which ends an active emulation mode.
- R5: Holding `ale_pin` low during reset while `psen_pin` is low does not enter emulation mode.
- R6: `emu_mode` changes only on the edge at which `int_rst` falls. A `rst_pin` pulse shorter than HOLD samples leaves both `emu_mode` and `int_rst` unchanged.
- R7: `p0_float` (1 = address/data port tri-stated) and `weak_pu` (1 = weak pull-ups only on the other ports and strobes) both equal `emu_mode`.
- R8: With `lock_any` = 1, `ea_eff` holds the external-access level that was captured while `int_rst` was high. Later changes on `ea_pin` are ignored until the next reset.
- R9: With `lock_any` = 0, `ea_eff` follows `ea_pin` with SYNC_STAGES edges of latency.
- R10: While `por_n` is low, `int_rst`, `emu_mode`, `p0_float`, `weak_pu` and `ea_eff` are all 0.
- R11: If `ale_pin` returns high during reset before `rst_pin` is released, emulation mode is not entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset from the analog detector, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ale_pin | input | 1 | Sampled level of the address-latch strobe pin |
| psen_pin | input | 1 | Sampled level of the program-store strobe pin |
| ea_pin | input | 1 | External-access strap pin level |
| lock_any | input | 1 | 1 when any program lock bit is programmed |
| int_rst | output | 1 | Qualified internal reset, active high |
| emu_mode | output | 1 | Emulation mode active |
| p0_float | output | 1 | Float the address/data port |
| weak_pu | output | 1 | Weak pull-ups only on the other ports and on the strobe pins |
| ea_eff | output | 1 | Effective external-access level seen by the core |

## Verification
Every result has a fixed latency, counted from the rising edge on which the changed input is first sampled. `int_rst` rises SYNC_STAGES+HOLD-1 edges after that edge. `int_rst` falls, and `emu_mode` with the pin controls update, SYNC_STAGES edges after it. The live external-access level follows after SYNC_STAGES edges. The driver tasks change inputs at a falling edge, and each expected value is queued with the exact cycle number at which it is due, with one check one cycle early so that a late or early transition is caught. The monitor pops each entry at the falling edge of its due cycle, when the outputs are settled.

// File: rtl/rstemu_pkg.sv
package rstemu_pkg;

   // Bit positions inside the synchronized pin bus
   localparam int unsigned PIN_RST  = 0;
   localparam int unsigned PIN_ALE  = 1;
   localparam int unsigned PIN_PSEN = 2;
   localparam int unsigned PIN_EA   = 3;
   localparam int unsigned PIN_CNT  = 4;

   // Pad control bundle driven while the emulation mode is active
   typedef struct packed {
      logic p0_float;
      logic weak_pu;
   } pin_ctl_t;

   function automatic pin_ctl_t pin_ctl_of(input logic emu);
      pin_ctl_t c;
      c.p0_float = emu;
      c.weak_pu  = emu;
      return c;
   endfunction

endpackage

// File: rtl/rstemu_sync.sv
module rstemu_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rstemu_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rstemu_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rstemu_qual.sv
module rstemu_qual #(
   parameter int unsigned CLKS_PER_MC = 12,
   parameter int unsigned RST_MCYCLES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_s,
   output logic int_rst,
   output logic rel_evt
);

   localparam int unsigned HOLD = CLKS_PER_MC * RST_MCYCLES;
   localparam int unsigned CW   = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("rstemu_qual: reset hold window must be at least one clock");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt     <= '0;
         int_rst <= 1'b0;
      end else if (!rst_s) begin
         cnt     <= '0;
         int_rst <= 1'b0;
      end else begin
         if (cnt != LAST) cnt <= cnt + 1'b1;
         if (cnt == LAST) int_rst <= 1'b1;
      end
   end

   // Release happens on the edge where a held reset sees the pin low
   assign rel_evt = int_rst & ~rst_s;

endmodule

// File: rtl/rstemu_mode.sv
module rstemu_mode
   import rstemu_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     int_rst,
   input  logic     rel_evt,
   input  logic     ale_s,
   input  logic     psen_s,
   output logic     emu,
   output pin_ctl_t ctl
);

   logic arm;

   // Request: strobe low with program-store high while in reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  arm <= 1'b0;
      else if (rel_evt)            arm <= 1'b0;
      else if (int_rst) begin
         if (!ale_s && psen_s)     arm <= 1'b1;
         else if (ale_s)           arm <= 1'b0;
      end
   end

   // Decision is taken only at reset release
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       emu <= 1'b0;
      else if (rel_evt) emu <= arm & ~ale_s;
   end

   always_comb ctl = pin_ctl_of(emu);

endmodule

// File: rtl/rstemu_ea.sv
module rstemu_ea #(
   parameter bit LOCK_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic int_rst,
   input  logic ea_s,
   input  logic lock_any,
   output logic ea_eff
);

   if (LOCK_SUPPORT) begin : g_lock
      logic ea_lat;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)       ea_lat <= 1'b0;
         else if (int_rst) ea_lat <= ea_s;
      end
      assign ea_eff = lock_any ? ea_lat : ea_s;
   end else begin : g_live
      logic unused_lock;
      logic unused_rst;
      logic unused_clk;
      logic unused_por;
      assign unused_lock = lock_any;
      assign unused_rst  = int_rst;
      assign unused_clk  = clk;
      assign unused_por  = por_n;
      assign ea_eff      = ea_s;
   end

endmodule

// File: rtl/rstemu_top.sv
module rstemu_top
   import rstemu_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned CLKS_PER_MC  = 12,
   parameter int unsigned RST_MCYCLES  = 2,
   parameter bit          LOCK_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin,
   input  logic ale_pin,
   input  logic psen_pin,
   input  logic ea_pin,
   input  logic lock_any,
   output logic int_rst,
   output logic emu_mode,
   output logic p0_float,
   output logic weak_pu,
   output logic ea_eff
);

   if (RST_MCYCLES < 1) begin : g_bad_mc
      $error("rstemu_top: RST_MCYCLES must be at least 1");
   end

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_s;
   logic               rel_evt;
   pin_ctl_t           ctl;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_RST]  = rst_pin;
      pins_raw[PIN_ALE]  = ale_pin;
      pins_raw[PIN_PSEN] = psen_pin;
      pins_raw[PIN_EA]   = ea_pin;
   end

   rstemu_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (PIN_CNT)
   ) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   rstemu_qual #(
      .CLKS_PER_MC (CLKS_PER_MC),
      .RST_MCYCLES (RST_MCYCLES)
   ) u_qual (
      .clk     (clk),
      .por_n   (por_n),
      .rst_s   (pins_s[PIN_RST]),
      .int_rst (int_rst),
      .rel_evt (rel_evt)
   );

   rstemu_mode u_mode (
      .clk     (clk),
      .por_n   (por_n),
      .int_rst (int_rst),
      .rel_evt (rel_evt),
      .ale_s   (pins_s[PIN_ALE]),
      .psen_s  (pins_s[PIN_PSEN]),
      .emu     (emu_mode),
      .ctl     (ctl)
   );

   rstemu_ea #(
      .LOCK_SUPPORT (LOCK_SUPPORT)
   ) u_ea (
      .clk      (clk),
      .por_n    (por_n),
      .int_rst  (int_rst),
      .ea_s     (pins_s[PIN_EA]),
      .lock_any (lock_any),
      .ea_eff   (ea_eff)
   );

   assign p0_float = ctl.p0_float;
   assign weak_pu  = ctl.weak_pu;

endmodule

// File: rtl/rstemu_chk.sv
module rstemu_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic por_n,
   input logic rst_pin,
   input logic ale_pin,
   input logic lock_any,
   input logic int_rst,
   input logic emu_mode,
   input logic ea_eff
);

   localparam int unsigned LAG = SYNC_STAGES + 1;

   AST_RST_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
      $rose(int_rst) |-> $past(rst_pin, LAG)); // R1

   AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
      $fell(int_rst) |-> !$past(rst_pin, LAG)); // R2

   AST_EMU_NEEDS_ALE_LOW: assert property (@(posedge clk) disable iff (!por_n)
      $rose(emu_mode) |-> !$past(ale_pin, LAG)); // R3

   AST_EMU_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
      (emu_mode != $past(emu_mode)) |-> $fell(int_rst)); // R6

   AST_EA_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
      (lock_any && $past(lock_any) && !int_rst && !$past(int_rst)) |-> $stable(ea_eff)); // R8

endmodule

bind rstemu_top rstemu_chk #(
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .rst_pin  (rst_pin),
   .ale_pin  (ale_pin),
   .lock_any (lock_any),
   .int_rst  (int_rst),
   .emu_mode (emu_mode),
   .ea_eff   (ea_eff)
);

// File: tb/rstemu_top_tb.sv
module rstemu_top_tb;

   localparam int SIG_RST = 0;
   localparam int SIG_EMU = 1;
   localparam int SIG_EA  = 2;
   localparam int SIG_P0F = 3;
   localparam int SIG_WPU = 4;

   typedef struct {
      int    due;
      int    sig;
      bit    exp;
      string req;
   } item_t;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_pin = 1'b0;
   logic ale_pin = 1'b1;
   logic psen_pin = 1'b1;
   logic ea_pin = 1'b0;
   logic lock_any = 1'b0;
   logic int_rst, emu_mode, p0_float, weak_pu, ea_eff;

   int    cyc = 0;
   int    tests = 0;
   int    fails = 0;
   bit    done = 1'b0;
   item_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rstemu_top u_dut (
      .clk      (clk),
      .por_n    (por_n),
      .rst_pin  (rst_pin),
      .ale_pin  (ale_pin),
      .psen_pin (psen_pin),
      .ea_pin   (ea_pin),
      .lock_any (lock_any),
      .int_rst  (int_rst),
      .emu_mode (emu_mode),
      .p0_float (p0_float),
      .weak_pu  (weak_pu),
      .ea_eff   (ea_eff)
   );

   function automatic bit actual(int sig);
      case (sig)
         SIG_RST: return int_rst;
         SIG_EMU: return emu_mode;
         SIG_EA:  return ea_eff;
         SIG_P0F: return p0_float;
         default: return weak_pu;
      endcase
   endfunction

   task automatic check(bit act, bit exp, string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: got %0b expected %0b", req, cyc, act, exp);
      end
   endtask

   task automatic expect_at(int d, int sig, bit v, string req);
      item_t it;
      it.due = cyc + d;
      it.sig = sig;
      it.exp = v;
      it.req = req;
      q.push_back(it);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: compare each queued expectation on its due cycle
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(actual(it.sig), it.exp, it.req);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R10: power-on state
      step(4);
      check(int_rst,  1'b0, "R10 int_rst");
      check(emu_mode, 1'b0, "R10 emu_mode");
      check(p0_float, 1'b0, "R10 p0_float");
      check(weak_pu,  1'b0, "R10 weak_pu");
      check(ea_eff,   1'b0, "R10 ea_eff");
      por_n = 1'b1;
      step(4);

      // R1: 23 high samples are too short
      rst_pin = 1'b1;
      expect_at(26, SIG_RST, 1'b0, "R1 short pulse");
      expect_at(30, SIG_RST, 1'b0, "R1 short pulse later");
      step(23);
      rst_pin = 1'b0;
      step(12);

      // R1/R2/R4: normal reset, exact rise and fall cycles
      rst_pin = 1'b1;
      expect_at(25, SIG_RST, 1'b0, "R1 not yet");
      expect_at(26, SIG_RST, 1'b1, "R1 asserted");
      step(40);
      rst_pin = 1'b0;
      expect_at(2, SIG_RST, 1'b1, "R2 still held");
      expect_at(3, SIG_RST, 1'b0, "R2 released");
      expect_at(3, SIG_EMU, 1'b0, "R4 normal reset");
      expect_at(3, SIG_P0F, 1'b0, "R7 p0_float normal");
      step(10);

      // R3/R7: emulation entry
      ale_pin = 1'b0;
      psen_pin = 1'b1;
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      expect_at(2, SIG_EMU, 1'b0, "R3 before release");
      expect_at(3, SIG_EMU, 1'b1, "R3 entered");
      expect_at(3, SIG_P0F, 1'b1, "R7 p0_float");
      expect_at(3, SIG_WPU, 1'b1, "R7 weak_pu");
      step(3);
      ale_pin = 1'b1;
      expect_at(8, SIG_EMU, 1'b1, "R6 persists after ALE high");
      step(10);

      // R6: short pulse while in emulation mode
      rst_pin = 1'b1;
      expect_at(15, SIG_RST, 1'b0, "R6 glitch no reset");
      expect_at(15, SIG_EMU, 1'b1, "R6 glitch keeps mode");
      step(10);
      rst_pin = 1'b0;
      step(10);

      // R4: normal reset exits emulation
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      expect_at(2, SIG_EMU, 1'b1, "R4 mode held in reset");
      expect_at(3, SIG_EMU, 1'b0, "R4 exited");
      expect_at(3, SIG_WPU, 1'b0, "R7 weak_pu cleared");
      step(10);

      // R5: PSEN low blocks the request
      ale_pin = 1'b0;
      psen_pin = 1'b0;
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      expect_at(3, SIG_EMU, 1'b0, "R5 psen low");
      step(6);
      ale_pin = 1'b1;
      psen_pin = 1'b1;
      step(6);

      // R11: ALE released before reset release
      ale_pin = 1'b0;
      rst_pin = 1'b1;
      step(35);
      ale_pin = 1'b1;
      step(5);
      rst_pin = 1'b0;
      expect_at(3, SIG_EMU, 1'b0, "R11 ALE released early");
      step(10);

      // R9: live strap path
      ea_pin = 1'b1;
      expect_at(1, SIG_EA, 1'b0, "R9 latency");
      expect_at(2, SIG_EA, 1'b1, "R9 follows high");
      step(5);
      ea_pin = 1'b0;
      expect_at(2, SIG_EA, 1'b0, "R9 follows low");
      step(5);

      // R8: strap captured in reset with a lock bit programmed
      lock_any = 1'b1;
      ea_pin = 1'b1;
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      step(5);
      ea_pin = 1'b0;
      expect_at(10, SIG_EA, 1'b1, "R8 strap frozen");
      step(12);
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      expect_at(6, SIG_EA, 1'b0, "R8 recaptured");
      step(10);

      while (q.size() > 0) step(1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule